// File: doc/BRIEF.md
# Reverse-Subtract Special-Case Resolver

This unit sits in front of the adder of an extended-precision floating-point datapath. It computes the reverse difference, first operand minus second operand. Each operand is 80 bits wide: a sign bit, a 15-bit biased exponent and a 64-bit significand with an explicit integer bit. The unit sorts each operand into zero, finite, infinity or NaN. When the difference can be settled without arithmetic, the unit produces the exact result. This covers signed zeros, infinities, NaNs and equal-magnitude cancellation. Every other pair is marked for the main adder.

The minuend operand `min_op` can carry a flag saying that it came from an integer. An integer zero then counts as positive zero. A 2-bit rounding-mode input sets the sign of an exact zero produced by cancellation. All outputs are registered, so a result appears one clock after its operands are presented.

Top module: `rsub_special`

## Requirements
- R1: While `rst` is high, all outputs are zero on the next clock edge. After reset, the outputs reflect the inputs sampled on the previous rising edge, one cycle of latency.
- R2: If either operand is a NaN (exponent all ones, fraction bits [62:0] nonzero), `spec_ok`=1 and `res` is that NaN with bit 62 set. If both are NaN, the one with the larger 64-bit significand is returned; on a tie, `min_op` is returned.
- R3: If both operands are infinite with the same sign, `inv_op`=1 and `res` is the default NaN 0xFFFF_C000_0000_0000_0000.
- R4: If exactly one operand is infinite, or both are infinite with opposite signs, `res` is an infinity. Its sign is positive for +inf in `min_op` or -inf in `sub_op`, and negative for -inf in `min_op` or +inf in `sub_op`.
- R5: If both operands are zero with opposite signs, the result is a zero with the sign of `min_op`, in every rounding mode.
- R6: An exact-zero difference of like-sign operands (two like-sign zeros, or equal finite magnitudes) gives -0 when `rnd` = 2'b01 (toward minus infinity). It gives +0 for `rnd` = 00 (nearest), 10 (toward plus infinity) and 11 (toward zero).
- R7: When `min_is_int`=1 and `min_op` is zero, `min_op` is treated as +0 whatever its sign bit.
- R8: With a zero `min_op` and a finite nonzero `sub_op`, `res` is `sub_op` with its sign inverted. With a finite nonzero `min_op` and a zero `sub_op`, `res` is `min_op`.
- R9: Two finite nonzero operands that do not cancel exactly give `hand_off`=1, `spec_ok`=0 and `res`=0.
- R10: After the first post-reset cycle, exactly one of `spec_ok` and `hand_off` is high, and `inv_op` is high only together with `spec_ok`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| min_op | input | 80 | Minuend (the operand subtracted from) |
| sub_op | input | 80 | Subtrahend |
| rnd | input | 2 | Rounding mode: 00 nearest, 01 down, 10 up, 11 toward zero |
| min_is_int | input | 1 | Minuend was converted from an integer |
| res | output | 80 | Resolved special result, zero on hand-off |
| spec_ok | output | 1 | Result is final |
| inv_op | output | 1 | Invalid-operation flag |
| hand_off | output | 1 | Main adder must compute the difference |

## Verification
The directed patterns cover every class pairing and the corner cases inside each pairing:
- every pairing of zero, finite, infinity and NaN classes, with both sign polarities;
- signed-zero pairs under all four rounding modes, which separates the like-sign rule from the opposite-sign rule;
- NaN pairs with either significand larger, and a tie, which shows whether the order comparison and the tie choice are right;
- negative zero with and without the integer flag, which shows whether the integer-zero rule is applied.

Randomly drawn class pairs are then compared on every clock against a behavioural model, so that equal-magnitude cancellation is checked apart from ordinary hand-off.

// File: rtl/rsub_pkg.sv
package rsub_pkg;
  typedef enum logic [1:0] {
    OP_ZERO   = 2'd0,
    OP_FINITE = 2'd1,
    OP_INF    = 2'd2,
    OP_NAN    = 2'd3
  } op_class_e;

  localparam logic [1:0] RM_NEAR = 2'b00;
  localparam logic [1:0] RM_DOWN = 2'b01;
  localparam logic [1:0] RM_UP   = 2'b10;
  localparam logic [1:0] RM_ZERO = 2'b11;
endpackage

// File: rtl/rsub_classify.sv
module rsub_classify
  import rsub_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64
) (
  input  logic [EXP_W+SIG_W:0] op,
  output op_class_e            cls
);
  localparam int W = 1 + EXP_W + SIG_W;

  logic [EXP_W-1:0] exp_f;
  logic [SIG_W-1:0] sig_f;
  logic             exp_max;
  logic             frac_nz;

  assign exp_f   = op[W-2 -: EXP_W];
  assign sig_f   = op[SIG_W-1:0];
  assign exp_max = &exp_f;
  assign frac_nz = |sig_f[SIG_W-2:0];

  always_comb begin
    if (exp_max)
      cls = frac_nz ? OP_NAN : OP_INF;
    else if (exp_f == '0 && sig_f == '0)
      cls = OP_ZERO;
    else
      cls = OP_FINITE;
  end
endmodule

// File: rtl/rsub_resolve.sv
module rsub_resolve
  import rsub_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64
) (
  input  logic [EXP_W+SIG_W:0] a_op,
  input  logic [EXP_W+SIG_W:0] b_op,
  input  op_class_e            a_cls,
  input  op_class_e            b_cls,
  input  logic [1:0]           rnd,
  input  logic                 a_is_int,
  output logic [EXP_W+SIG_W:0] res,
  output logic                 spec_ok,
  output logic                 inv_op,
  output logic                 hand_off
);
  localparam int W    = 1 + EXP_W + SIG_W;
  localparam int QBIT = SIG_W - 2;
  localparam logic [W-1:0] DEF_NAN =
    {1'b1, {EXP_W{1'b1}}, 2'b11, {(SIG_W-2){1'b0}}};

  logic         a_sign, b_sign, down_sign;
  logic [W-1:0] a_eff, b_neg, nan_pick;

  assign a_sign    = a_op[W-1] & ~(a_is_int && a_cls == OP_ZERO);
  assign b_sign    = b_op[W-1];
  assign a_eff     = {a_sign, a_op[W-2:0]};
  assign b_neg     = {~b_sign, b_op[W-2:0]};
  assign down_sign = (rnd == RM_DOWN);

  always_comb begin
    if (a_cls == OP_NAN && b_cls == OP_NAN)
      nan_pick = (b_op[SIG_W-1:0] > a_op[SIG_W-1:0]) ? b_op : a_op;
    else if (a_cls == OP_NAN)
      nan_pick = a_op;
    else
      nan_pick = b_op;
    nan_pick[QBIT] = 1'b1;
  end

  always_comb begin
    res      = '0;
    spec_ok  = 1'b1;
    inv_op   = 1'b0;
    hand_off = 1'b0;
    if (a_cls == OP_NAN || b_cls == OP_NAN) begin
      res = nan_pick;
    end else if (a_cls == OP_INF && b_cls == OP_INF) begin
      if (a_sign == b_sign) begin
        inv_op = 1'b1;
        res    = DEF_NAN;
      end else begin
        res = a_eff;
      end
    end else if (a_cls == OP_INF) begin
      res = a_eff;
    end else if (b_cls == OP_INF) begin
      res = b_neg;
    end else if (a_cls == OP_ZERO && b_cls == OP_ZERO) begin
      res = {(a_sign != b_sign) ? a_sign : down_sign, {(W-1){1'b0}}};
    end else if (a_cls == OP_ZERO) begin
      res = b_neg;
    end else if (b_cls == OP_ZERO) begin
      res = a_eff;
    end else if (a_sign == b_sign && a_op[W-2:0] == b_op[W-2:0]) begin
      res = {down_sign, {(W-1){1'b0}}};
    end else begin
      spec_ok  = 1'b0;
      hand_off = 1'b1;
    end
  end
endmodule

// File: rtl/rsub_special.sv
module rsub_special
  import rsub_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [EXP_W+SIG_W:0] min_op,
  input  logic [EXP_W+SIG_W:0] sub_op,
  input  logic [1:0]           rnd,
  input  logic                 min_is_int,
  output logic [EXP_W+SIG_W:0] res,
  output logic                 spec_ok,
  output logic                 inv_op,
  output logic                 hand_off
);
  localparam int W     = 1 + EXP_W + SIG_W;
  localparam int N_OPS = 2;

  logic [W-1:0] ops [N_OPS];
  op_class_e    cls [N_OPS];
  logic [W-1:0] res_c;
  logic         spec_c, inv_c, hand_c;

  assign ops[0] = min_op;
  assign ops[1] = sub_op;

  for (genvar g = 0; g < N_OPS; g++) begin : g_cls
    rsub_classify #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_cls (
      .op  (ops[g]),
      .cls (cls[g])
    );
  end

  rsub_resolve #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_res (
    .a_op     (min_op),
    .b_op     (sub_op),
    .a_cls    (cls[0]),
    .b_cls    (cls[1]),
    .rnd      (rnd),
    .a_is_int (min_is_int),
    .res      (res_c),
    .spec_ok  (spec_c),
    .inv_op   (inv_c),
    .hand_off (hand_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res      <= '0;
      spec_ok  <= 1'b0;
      inv_op   <= 1'b0;
      hand_off <= 1'b0;
    end else begin
      res      <= res_c;
      spec_ok  <= spec_c;
      inv_op   <= inv_c;
      hand_off <= hand_c;
    end
  end
endmodule

module rsub_special_chk #(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64
) (
  input logic                 clk,
  input logic                 rst,
  input logic [EXP_W+SIG_W:0] min_op,
  input logic [EXP_W+SIG_W:0] sub_op,
  input logic [1:0]           rnd,
  input logic                 min_is_int,
  input logic [EXP_W+SIG_W:0] res,
  input logic                 spec_ok,
  input logic                 inv_op,
  input logic                 hand_off
);
  localparam int W = 1 + EXP_W + SIG_W;
  localparam logic [W-1:0] DEF_NAN =
    {1'b1, {EXP_W{1'b1}}, 2'b11, {(SIG_W-2){1'b0}}};
  localparam logic [W-1:0] POS_INF =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(SIG_W-1){1'b0}}};
  localparam logic [W-1:0] INF_MAG = {1'b0, POS_INF[W-2:0]};

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  logic min_pinf, sub_pinf, sub_inf, sub_nan, min_zero, sub_zero;
  assign min_pinf = (min_op == POS_INF);
  assign sub_pinf = (sub_op == POS_INF);
  assign sub_inf  = ({1'b0, sub_op[W-2:0]} == INF_MAG);
  assign sub_nan  = (&sub_op[W-2 -: EXP_W]) && (|sub_op[SIG_W-2:0]);
  assign min_zero = (min_op[W-2:0] == '0);
  assign sub_zero = (sub_op[W-2:0] == '0);

  AST_ONE_PATH: assert property (@(posedge clk) disable iff (rst)
    armed |-> (spec_ok ^ hand_off)); // R10

  AST_INVALID_SPECIAL: assert property (@(posedge clk) disable iff (rst)
    inv_op |-> spec_ok); // R10

  AST_INVALID_NAN: assert property (@(posedge clk) disable iff (rst)
    inv_op |-> (res == DEF_NAN)); // R3

  AST_HANDOFF_ZERO: assert property (@(posedge clk) disable iff (rst)
    hand_off |-> (res == '0)); // R9

  AST_PINF_MIN: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(min_pinf && !sub_inf && !sub_nan)) |-> (res == POS_INF)); // R4

  AST_PINF_SUB: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(sub_pinf && !min_pinf && min_zero)) |-> (res == {1'b1, POS_INF[W-2:0]})); // R4

  AST_ZERO_NEAR: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(min_zero && sub_zero && !min_is_int &&
                    min_op[W-1] == sub_op[W-1] && rnd != 2'b01))
    |-> (res == '0)); // R6
endmodule

bind rsub_special rsub_special_chk #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .min_op     (min_op),
  .sub_op     (sub_op),
  .rnd        (rnd),
  .min_is_int (min_is_int),
  .res        (res),
  .spec_ok    (spec_ok),
  .inv_op     (inv_op),
  .hand_off   (hand_off)
);

// File: tb/tb_rsub_special.sv
`timescale 1ns/1ps
module tb_rsub_special;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [79:0] min_op = '0, sub_op = '0;
  logic [1:0]  rnd = 2'b00;
  logic        min_is_int = 1'b0;
  logic [79:0] res;
  logic        spec_ok, inv_op, hand_off;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  rsub_special dut (
    .clk(clk), .rst(rst), .min_op(min_op), .sub_op(sub_op), .rnd(rnd),
    .min_is_int(min_is_int), .res(res), .spec_ok(spec_ok),
    .inv_op(inv_op), .hand_off(hand_off)
  );

  localparam logic [79:0] PZ   = 80'h0;
  localparam logic [79:0] NZ   = {1'b1, 79'h0};
  localparam logic [79:0] PINF = 80'h7FFF_8000_0000_0000_0000;
  localparam logic [79:0] NINF = 80'hFFFF_8000_0000_0000_0000;
  localparam logic [79:0] ONE  = 80'h3FFF_8000_0000_0000_0000;
  localparam logic [79:0] NONE = 80'hBFFF_8000_0000_0000_0000;
  localparam logic [79:0] TWO  = 80'h4000_8000_0000_0000_0000;
  localparam logic [79:0] SNAN = 80'h7FFF_8000_0000_0000_0005;
  localparam logic [79:0] QNAN = 80'hFFFF_C000_0000_0000_0009;
  localparam logic [79:0] DNAN = 80'hFFFF_C000_0000_0000_0000;

  function automatic int kind(logic [79:0] v);
    if (v[78:64] == 15'h7FFF) return (v[62:0] != 0) ? 3 : 2;
    if (v[78:0] == 0) return 0;
    return 1;
  endfunction

  // behavioural reference: {res, spec_ok, inv_op, hand_off}
  function automatic logic [82:0] model(logic [79:0] a, logic [79:0] b,
                                        logic [1:0] rm, logic ai);
    int ka = kind(a);
    int kb = kind(b);
    logic sa = (ai && ka == 0) ? 1'b0 : a[79];
    logic sb = b[79];
    logic [79:0] r;
    logic zs = (rm == 2'b01);
    if (ka == 3 || kb == 3) begin
      if (ka == 3 && kb == 3) r = (b[63:0] > a[63:0]) ? b : a;
      else r = (ka == 3) ? a : b;
      r[62] = 1'b1;
      return {r, 3'b100};
    end
    if (ka == 2 && kb == 2)
      return (sa == sb) ? {DNAN, 3'b110} : {sa, a[78:0], 3'b100};
    if (ka == 2) return {sa, a[78:0], 3'b100};
    if (kb == 2) return {~sb, b[78:0], 3'b100};
    if (ka == 0 && kb == 0)
      return {(sa != sb) ? sa : zs, 79'h0, 3'b100};
    if (ka == 0) return {~sb, b[78:0], 3'b100};
    if (kb == 0) return {a, 3'b100};
    if (sa == sb && a[78:0] == b[78:0]) return {zs, 79'h0, 3'b100};
    return {80'h0, 3'b001};
  endfunction

  task automatic apply(input logic [79:0] a, input logic [79:0] b,
                       input logic [1:0] rm, input logic ai, input string tag);
    logic [82:0] exp_v;
    min_op = a; sub_op = b; rnd = rm; min_is_int = ai;
    exp_v = model(a, b, rm, ai);
    @(posedge clk);
    @(negedge clk);
    checks++;
    if ({res, spec_ok, inv_op, hand_off} !== exp_v) begin
      errors++;
      $display("FAIL %s got res=%h s/i/h=%b%b%b expected res=%h s/i/h=%b",
               tag, res, spec_ok, inv_op, hand_off, exp_v[82:3], exp_v[2:0]);
    end
  endtask

  function automatic logic [79:0] rand_op(int k);
    logic [79:0] v;
    v[79] = 1'($urandom_range(0, 1));
    case (k)
      0: v[78:0] = '0;
      2: v[78:0] = PINF[78:0];
      3: v[78:0] = {15'h7FFF, 1'b1, 1'b1, 60'h0, 2'($urandom_range(0, 3))};
      default: v[78:0] = {15'(16'h3FFE + $urandom_range(0, 2)), 1'b1,
                          61'h0, 2'($urandom_range(0, 3))};
    endcase
    return v;
  endfunction

  initial begin
    repeat (2) @(negedge clk);
    checks++; // R1 reset state
    if ({res, spec_ok, inv_op, hand_off} !== 83'h0) begin
      errors++;
      $display("FAIL R1 reset got %h expected 0", {res, spec_ok, inv_op, hand_off});
    end
    rst = 1'b0;
    apply(ONE, TWO, 2'b00, 1'b0, "R1 latency / R9 handoff");
    apply(SNAN, ONE, 2'b00, 1'b0, "R2 nan in min");
    apply(ONE, QNAN, 2'b00, 1'b0, "R2 nan in sub");
    apply(SNAN, QNAN, 2'b00, 1'b0, "R2 larger sub significand");
    apply(QNAN, SNAN, 2'b00, 1'b0, "R2 larger min significand");
    apply(SNAN, SNAN | 80'h8000_0000_0000_0000_0000, 2'b00, 1'b0, "R2 tie");
    apply(PINF, PINF, 2'b00, 1'b0, "R3 +inf-+inf");
    apply(NINF, NINF, 2'b01, 1'b0, "R3 -inf--inf");
    apply(PINF, NINF, 2'b00, 1'b0, "R4 +inf--inf");
    apply(NINF, PINF, 2'b00, 1'b0, "R4 -inf-+inf");
    apply(PINF, ONE, 2'b00, 1'b0, "R4 +inf-fin");
    apply(ONE, PINF, 2'b00, 1'b0, "R4 fin-+inf");
    apply(NZ, NINF, 2'b00, 1'b0, "R4 zero--inf");
    apply(PZ, NZ, 2'b01, 1'b0, "R5 +0--0 down");
    apply(NZ, PZ, 2'b00, 1'b0, "R5 -0-+0 near");
    for (int m = 0; m < 4; m++) begin
      apply(PZ, PZ, 2'(m), 1'b0, "R6 +0-+0");
      apply(NZ, NZ, 2'(m), 1'b0, "R6 -0--0");
      apply(TWO, TWO, 2'(m), 1'b0, "R6 equal finite");
    end
    apply(NZ, NZ, 2'b00, 1'b1, "R7 int zero vs -0 near");
    apply(NZ, PZ, 2'b10, 1'b1, "R7 int zero vs +0");
    apply(NZ, PZ, 2'b10, 1'b0, "R7 control non-int -0");
    apply(PZ, ONE, 2'b00, 1'b0, "R8 0-fin");
    apply(NZ, NONE, 2'b00, 1'b0, "R8 0-negfin");
    apply(TWO, NZ, 2'b00, 1'b0, "R8 fin-0");
    apply(ONE, NONE, 2'b00, 1'b0, "R9 opposite sign equal mag");
    for (int i = 0; i < 200; i++)
      apply(rand_op($urandom_range(0, 3)), rand_op($urandom_range(0, 3)),
            2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), "R10 random");
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    checks++; // R1 mid-run reset
    if ({res, spec_ok, inv_op, hand_off} !== 83'h0) begin
      errors++;
      $display("FAIL R1 reset got %h expected 0", {res, spec_ok, inv_op, hand_off});
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule